// File: doc/BRIEF.md
# Passive-Mode FPGA Configuration Sequencer

This block loads a configuration bitstream into a target FPGA over its passive configuration pins. A start pulse names the load mode and the byte count. The block then drives the active-low configuration reset low for a timed pulse and releases it. It waits out the setup time and then clocks the bytes in. Bytes arrive on a valid/ready handshake. A slow producer stalls the sequence while the configuration clock is held low.

Three load modes share one engine. In serial mode each byte goes out bit by bit, least significant bit first, on data pin 0. In parallel mode the whole byte goes out on an 8-bit bus with one clock pulse. In secure parallel mode the byte gets three more pulses after its data pulse. The synchronized status input must be high before each byte is taken. After the last byte the block drives one trailing rising edge and holds the clock high for the settle time. It then samples the synchronized done input. A failure after the reset pulse has begun raises abort together with failure. The number of bytes already accepted stays on an output until the next start.

Top module: `cfg_load_seq`

## Requirements
- R1: An accepted start drives `ncfg_o` low for exactly RST_CYC = CLK_MHZ*RST_US cycles, then high. While idle, `ncfg_o` is high and `cclk_o` is low.
- R2: At least WAIT_CYC = CLK_MHZ*WAIT_US cycles separate the rise of `ncfg_o` from the first rise of `cclk_o`. `cclk_o` stays low during the reset pulse and the wait.
- R3: Each data pulse holds `cclk_o` low for LO_CYC cycles with the data already on the pins, then high for HI_CYC cycles. The only other high phase is the trailing one, which lasts WAIT_CYC cycles.
- R4: Mode 0 (serial) gives each byte 8 pulses. On pulse k (k = 0 to 7), `cdata_o[0]` carries bit k of the byte and `cdata_o[7:1]` are 0.
- R5: Mode 1 (parallel) gives each byte one pulse, with the whole byte on `cdata_o[7:0]`.
- R6: Mode 2 (secure parallel) gives each byte 4 pulses. The byte is held on `cdata_o` for all four.
- R7: If the synchronized status is low when the next byte is due, the block raises `fail_o` and `abort_o` in the same cycle and gives no further clock pulses. `sent_o` then holds the number of bytes accepted before that point.
- R8: After the last byte, the block drives one trailing rising edge and keeps `cclk_o` high for WAIT_CYC cycles. It then samples the synchronized done input. High gives `ok_o`. Low gives `fail_o` together with `abort_o`.
- R9: A start with `byte_cnt_i` = 0 or `mode_i` = 3 is rejected. `fail_o` pulses in the cycle after the start, `abort_o` stays low, `busy_o` stays low, and the reset and clock pins do not move.
- R10: `ready_o` is high only while a byte is awaited and the status is high. During a stall in that state `cclk_o` stays low.
- R11: `sent_o` clears to 0 on any start seen while idle and counts accepted bytes. Outside a load it holds its value until the next start.
- R12: Each load ends with exactly one single-cycle pulse of `ok_o` or `fail_o`. `abort_o` only pulses together with `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken while idle |
| mode_i | input | 2 | 0 serial, 1 parallel, 2 secure parallel, 3 unsupported |
| byte_cnt_i | input | CNT_W | Number of bytes to load |
| data_i | input | 8 | Stream byte |
| valid_i | input | 1 | Stream byte valid |
| ready_o | output | 1 | Stream byte accepted when high with valid_i |
| ncfg_o | output | 1 | Active-low configuration reset to the target |
| cclk_o | output | 1 | Configuration clock to the target |
| cdata_o | output | 8 | Configuration data (bit 0 only in serial mode) |
| status_i | input | 1 | Target status, high while healthy |
| done_i | input | 1 | Target configuration-done |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Success pulse |
| fail_o | output | 1 | Failure pulse |
| abort_o | output | 1 | Abort pulse, with failure after the reset pulse began |
| sent_o | output | CNT_W | Bytes accepted in the current or last load |

## Verification
A wrong pulse counter or wrong mode decode shows up on the configuration clock within one byte time. The count of rising edges or the data seen on them stops matching the mode's pulses per byte. A mistimed reset or wait counter is visible at the first clock rise, as a wrong reset-pulse width or a short gap. A broken status or done path shows up at the end of the load: the wrong result pulse or a wrong `sent_o`, and trailing clock edges after a status drop. A stall that leaks into the clock puts `cclk_o` high while `ready_o` is high, in the same cycle.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_SER = 2'd0,
    MODE_PAR = 2'd1,
    MODE_SEC = 2'd2,
    MODE_BAD = 2'd3
  } load_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RLO,
    ST_RWAIT,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_TLOW,
    ST_TRAIL
  } seq_state_e;

  function automatic logic [3:0] pulses_per_byte(load_mode_e m);
    case (m)
      MODE_SER: return 4'd8;
      MODE_SEC: return 4'd4;
      default:  return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_fmt.sv
module cfg_fmt
  import cfg_load_pkg::*;
(
  input  load_mode_e        mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [2:0]        idx_i,
  output logic [BYTE_W-1:0] pins_o
);
  logic ser;
  assign ser = (mode_i == MODE_SER);

  for (genvar g = 0; g < BYTE_W; g++) begin : g_pin
    if (g == 0) begin : g_lsb
      assign pins_o[g] = ser ? byte_i[idx_i] : byte_i[0];
    end else begin : g_upper
      assign pins_o[g] = ser ? 1'b0 : byte_i[g];
    end
  end
endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 250,
  parameter int unsigned RST_US  = 5,
  parameter int unsigned WAIT_US = 100,
  parameter int unsigned LO_CYC  = 2,
  parameter int unsigned HI_CYC  = 2,
  parameter int unsigned CNT_W   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              ncfg_o,
  output logic              cclk_o,
  output logic [BYTE_W-1:0] cdata_o,
  input  logic              status_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              ok_o,
  output logic              fail_o,
  output logic              abort_o,
  output logic [CNT_W-1:0]  sent_o
);
  localparam int unsigned RST_CYC  = CLK_MHZ * RST_US;
  localparam int unsigned WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int unsigned MAX_A    = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int unsigned MAX_B    = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int unsigned MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned TW       = $clog2(MAX_C + 1);
  localparam logic [TW-1:0] RST_LD  = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] LO_LD   = TW'(LO_CYC - 1);
  localparam logic [TW-1:0] HI_LD   = TW'(HI_CYC - 1);

  seq_state_e        state_q, state_d;
  load_mode_e        mode_q;
  logic [CNT_W-1:0]  total_q, acc_q;
  logic [BYTE_W-1:0] byte_q;
  logic [2:0]        idx_q;
  logic              ok_q, fail_q, abort_q, ncfg_q, cclk_q;

  logic [1:0] sync_q;
  logic       status_s, done_s;
  logic       t_load, t_zero;
  logic [TW-1:0] t_val;
  logic       start_ok, accept, adv, set_ok, set_fail, set_abort, arm;
  logic [3:0] ppb;
  logic       last_pulse, last_byte;

  cfg_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, status_i}),
    .q_o   (sync_q)
  );
  assign status_s = sync_q[0];
  assign done_s   = sync_q[1];

  cfg_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .val_i (t_val),
    .zero_o(t_zero)
  );

  cfg_fmt u_fmt (
    .mode_i(mode_q),
    .byte_i(byte_q),
    .idx_i (idx_q),
    .pins_o(cdata_o)
  );

  assign start_ok   = start_i && (byte_cnt_i != '0) && (load_mode_e'(mode_i) != MODE_BAD);
  assign ppb        = pulses_per_byte(mode_q);
  assign last_pulse = (idx_q == 3'(ppb - 4'd1));
  assign last_byte  = (acc_q == total_q);
  assign ready_o    = (state_q == ST_FETCH) && status_s;
  assign accept     = ready_o && valid_i;

  always_comb begin
    state_d   = state_q;
    t_load    = 1'b0;
    t_val     = '0;
    adv       = 1'b0;
    set_ok    = 1'b0;
    set_fail  = 1'b0;
    set_abort = 1'b0;
    arm       = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (start_ok) begin
            arm     = 1'b1;
            state_d = ST_RLO;
            t_load  = 1'b1;
            t_val   = RST_LD;
          end else begin
            set_fail = 1'b1;
          end
        end
      end
      ST_RLO: if (t_zero) begin
        state_d = ST_RWAIT;
        t_load  = 1'b1;
        t_val   = WAIT_LD;
      end
      ST_RWAIT: if (t_zero) state_d = ST_FETCH;
      ST_FETCH: begin
        if (!status_s) begin
          set_fail  = 1'b1;
          set_abort = 1'b1;
          state_d   = ST_IDLE;
        end else if (valid_i) begin
          state_d = ST_LOW;
          t_load  = 1'b1;
          t_val   = LO_LD;
        end
      end
      ST_LOW: if (t_zero) begin
        state_d = ST_HIGH;
        t_load  = 1'b1;
        t_val   = HI_LD;
      end
      ST_HIGH: if (t_zero) begin
        if (!last_pulse) begin
          adv     = 1'b1;
          state_d = ST_LOW;
          t_load  = 1'b1;
          t_val   = LO_LD;
        end else if (last_byte) begin
          state_d = ST_TLOW;
          t_load  = 1'b1;
          t_val   = LO_LD;
        end else begin
          state_d = ST_FETCH;
        end
      end
      ST_TLOW: if (t_zero) begin
        state_d = ST_TRAIL;
        t_load  = 1'b1;
        t_val   = WAIT_LD;
      end
      ST_TRAIL: if (t_zero) begin
        state_d = ST_IDLE;
        if (done_s) begin
          set_ok = 1'b1;
        end else begin
          set_fail  = 1'b1;
          set_abort = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_PAR;
      total_q <= '0;
      acc_q   <= '0;
      byte_q  <= '0;
      idx_q   <= '0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      abort_q <= 1'b0;
      ncfg_q  <= 1'b1;
      cclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= set_ok;
      fail_q  <= set_fail;
      abort_q <= set_abort;
      // pins follow the next state so they switch with it, glitch free
      ncfg_q  <= (state_d != ST_RLO);
      cclk_q  <= (state_d == ST_HIGH) || (state_d == ST_TRAIL);
      if (state_q == ST_IDLE && start_i) acc_q <= '0;
      if (arm) begin
        mode_q  <= load_mode_e'(mode_i);
        total_q <= byte_cnt_i;
      end
      if (accept) begin
        byte_q <= data_i;
        idx_q  <= '0;
        acc_q  <= acc_q + CNT_W'(1);
      end else if (adv) begin
        idx_q <= idx_q + 3'd1;
      end
    end
  end

  assign ncfg_o  = ncfg_q;
  assign cclk_o  = cclk_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign ok_o    = ok_q;
  assign fail_o  = fail_q;
  assign abort_o = abort_q;
  assign sent_o  = acc_q;
endmodule

// File: rtl/cfg_load_chk.sv
module cfg_load_chk #(
  parameter int unsigned RST_CYC  = 5,
  parameter int unsigned WAIT_CYC = 100,
  parameter int unsigned HI_CYC   = 2,
  parameter int unsigned CNT_W    = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] byte_cnt_i,
  input logic             ready_o,
  input logic             ncfg_o,
  input logic             cclk_o,
  input logic             busy_o,
  input logic             ok_o,
  input logic             fail_o,
  input logic             abort_o,
  input logic [CNT_W-1:0] sent_o
);
  logic [31:0] lo_run_q, hi_run_q;
  logic        ncfg_prev_q, cclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q    <= '0;
      hi_run_q    <= '0;
      ncfg_prev_q <= 1'b1;
      cclk_prev_q <= 1'b0;
    end else begin
      lo_run_q    <= ncfg_o ? 32'd0 : lo_run_q + 32'd1;
      hi_run_q    <= cclk_o ? hi_run_q + 32'd1 : 32'd0;
      ncfg_prev_q <= ncfg_o;
      cclk_prev_q <= cclk_o;
    end
  end

  a_r1_rst_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ncfg_o && !ncfg_prev_q) |-> (lo_run_q == RST_CYC));

  a_r2_no_clk_in_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ncfg_o |-> !cclk_o);

  a_r3_high_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cclk_o && cclk_prev_q) |-> (hi_run_q == HI_CYC || hi_run_q == WAIT_CYC));

  a_r9_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (byte_cnt_i == '0 || mode_i == 2'd3))
      |=> (fail_o && !abort_o && !busy_o && ncfg_o));

  a_r10_ready_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !cclk_o);

  a_r11_sent_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(sent_o));

  a_r12_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fail_o));

  a_r12_abort_with_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> fail_o);

  a_r12_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || fail_o) |=> !(ok_o || fail_o));
endmodule

bind cfg_load_seq cfg_load_chk #(
  .RST_CYC (RST_CYC),
  .WAIT_CYC(WAIT_CYC),
  .HI_CYC  (HI_CYC),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .mode_i    (mode_i),
  .byte_cnt_i(byte_cnt_i),
  .ready_o   (ready_o),
  .ncfg_o    (ncfg_o),
  .cclk_o    (cclk_o),
  .busy_o    (busy_o),
  .ok_o      (ok_o),
  .fail_o    (fail_o),
  .abort_o   (abort_o),
  .sent_o    (sent_o)
);

// File: tb/sim_cfg_load_seq.sv
`timescale 1ns/1ps
module sim_cfg_load_seq;
  localparam int unsigned CLK_MHZ = 1;
  localparam int unsigned RST_US  = 5;
  localparam int unsigned WAIT_US = 100;
  localparam int unsigned LO_CYC  = 2;
  localparam int unsigned HI_CYC  = 2;
  localparam int unsigned CNT_W   = 8;
  localparam int RST_CYC  = CLK_MHZ * RST_US;
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] nb;
    logic [7:0] seed;
    logic       done;
    logic       stall;
    logic [7:0] fail_at;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd3, 8'hA5, 1'b1, 1'b0, 8'hFF},
    '{2'd1, 8'd5, 8'h3C, 1'b1, 1'b1, 8'hFF},
    '{2'd2, 8'd4, 8'h81, 1'b1, 1'b0, 8'hFF},
    '{2'd1, 8'd4, 8'h10, 1'b0, 1'b0, 8'hFF},
    '{2'd0, 8'd4, 8'h5A, 1'b1, 1'b0, 8'd2},
    '{2'd2, 8'd3, 8'h77, 1'b1, 1'b0, 8'd0},
    '{2'd2, 8'd2, 8'hC3, 1'b1, 1'b1, 8'hFF}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, valid_i = 1'b0, status_i = 1'b1, done_i = 1'b1;
  logic [1:0] mode_i = 2'd0;
  logic [CNT_W-1:0] byte_cnt_i = '0;
  logic [7:0] data_i = '0;
  logic ready_o, ncfg_o, cclk_o, busy_o, ok_o, fail_o, abort_o;
  logic [7:0] cdata_o;
  logic [CNT_W-1:0] sent_o;

  cfg_load_seq #(
    .CLK_MHZ(CLK_MHZ), .RST_US(RST_US), .WAIT_US(WAIT_US),
    .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .CNT_W(CNT_W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .byte_cnt_i(byte_cnt_i), .data_i(data_i), .valid_i(valid_i), .ready_o(ready_o),
    .ncfg_o(ncfg_o), .cclk_o(cclk_o), .cdata_o(cdata_o), .status_i(status_i),
    .done_i(done_i), .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o),
    .abort_o(abort_o), .sent_o(sent_o)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit running = 0, pend = 0, seen_rst = 0, seen_clk = 0, cclk_prev = 0;
  logic [1:0] cur_mode = 2'd0;
  logic [7:0] cur_seed = '0;
  int cur_nb = 0, cur_fk = -1, fidx = 0, stall_cnt = 0;
  bit cur_stall = 0;
  int edge_cnt = 0, data_bad = 0, low_cnt = 0, gap = 0, glitch_bad = 0, hi_run = 0, hiw_bad = 0;

  function automatic logic [7:0] pat(logic [7:0] s, int j);
    return s + 8'(j * 37);
  endfunction

  function automatic int ppb(logic [1:0] m);
    case (m)
      2'd0: return 8;
      2'd2: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic chk_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(string tag, int act, int lim);
    total++;
    if (act < lim) begin
      bad++;
      $display("FAIL %s act=%0d exp>=%0d", tag, act, lim);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // monitor and byte feeder, all on the falling edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cclk_o && !cclk_prev) begin
        int j, b;
        logic [7:0] p, e;
        j = edge_cnt / ppb(cur_mode);
        b = edge_cnt % ppb(cur_mode);
        if (j < cur_nb) begin
          p = pat(cur_seed, j);
          e = (cur_mode == 2'd0) ? {7'b0, p[b]} : p;
          if (cdata_o != e) data_bad++;
        end
        edge_cnt++;
      end
      if (cclk_o) hi_run++;
      else begin
        if (cclk_prev && hi_run != HI_CYC && hi_run != WAIT_CYC) hiw_bad++;
        hi_run = 0;
      end
      cclk_prev = cclk_o;
      if (ready_o && cclk_o) glitch_bad++;
      if (!ncfg_o) begin
        low_cnt++;
        seen_rst = 1;
      end else if (seen_rst && !seen_clk) begin
        if (cclk_o) seen_clk = 1;
        else gap++;
      end
      if (pend) begin
        fidx++;
        stall_cnt = cur_stall ? 3 : 0;
        if (fidx == cur_fk) status_i = 1'b0;
      end
      if (stall_cnt > 0) begin
        valid_i = 1'b0;
        stall_cnt--;
      end else begin
        valid_i = running && (fidx < cur_nb);
      end
      data_i = pat(cur_seed, fidx);
      pend = valid_i && ready_o;
    end
  end

  task automatic clear_mon();
    pend = 0; fidx = 0; stall_cnt = 0; edge_cnt = 0; data_bad = 0;
    low_cnt = 0; gap = 0; seen_rst = 0; seen_clk = 0; glitch_bad = 0; hiw_bad = 0;
  endtask

  task automatic run_vec(vec_t v);
    int n, pp, e_ok, e_abort, e_sent, e_edges;
    logic g_ok, g_fail, g_abort;
    logic [CNT_W-1:0] s0;
    string dtag;
    @(negedge clk);
    cur_mode = v.mode; cur_nb = int'(v.nb); cur_seed = v.seed; cur_stall = v.stall;
    cur_fk = (v.fail_at == 8'hFF) ? -1 : int'(v.fail_at);
    status_i = (cur_fk != 0);
    done_i = v.done;
    clear_mon();
    running = 1;
    start_i = 1'b1; mode_i = v.mode; byte_cnt_i = CNT_W'(v.nb);
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!(ok_o || fail_o) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    g_ok = ok_o; g_fail = fail_o; g_abort = abort_o;
    running = 0;
    pp = ppb(v.mode);
    if (cur_fk >= 0) begin
      e_ok = 0; e_abort = 1; e_sent = cur_fk; e_edges = cur_fk * pp;
    end else begin
      e_ok = v.done ? 1 : 0; e_abort = v.done ? 0 : 1;
      e_sent = cur_nb; e_edges = cur_nb * pp + 1;
    end
    dtag = (v.mode == 2'd0) ? "R4 serial data" : (v.mode == 2'd1) ? "R5 parallel data" : "R6 secure data";
    chk_eq((cur_fk >= 0) ? "R7 ok" : "R8 ok", g_ok, e_ok);
    chk_eq("R12 fail", g_fail, 1 - e_ok);
    chk_eq((cur_fk >= 0) ? "R7 abort" : "R8 abort", g_abort, e_abort);
    chk_eq("R7 sent", int'(sent_o), e_sent);
    s0 = sent_o;
    repeat (5) @(negedge clk);
    chk_eq({dtag, " edges"}, edge_cnt, e_edges);
    chk_eq(dtag, data_bad, 0);
    chk_eq("R1 reset width", low_cnt, RST_CYC);
    if (e_edges > 0) chk_ge("R2 setup gap", gap, WAIT_CYC);
    chk_eq("R3 high width", hiw_bad, 0);
    chk_eq("R10 clk low in fetch", glitch_bad, 0);
    chk_eq("R11 sent held", int'(sent_o), int'(s0));
    chk_eq("R12 idle after", busy_o, 0);
    status_i = 1'b1;
    done_i = 1'b1;
  endtask

  task automatic run_reject(logic [1:0] m, int nb);
    @(negedge clk);
    clear_mon();
    start_i = 1'b1; mode_i = m; byte_cnt_i = CNT_W'(nb);
    @(negedge clk);
    start_i = 1'b0;
    chk_eq("R9 reject fail", fail_o, 1);
    chk_eq("R9 reject abort", abort_o, 0);
    chk_eq("R9 reject busy", busy_o, 0);
    chk_eq("R11 sent cleared", int'(sent_o), 0);
    repeat (10) @(negedge clk);
    chk_eq("R9 no reset pulse", low_cnt, 0);
    chk_eq("R9 no clock", edge_cnt, 0);
    chk_eq("R9 still idle", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_eq("R1 reset ncfg high", ncfg_o, 1);
    chk_eq("R1 reset clk low", cclk_o, 0);
    chk_eq("R10 reset ready low", ready_o, 0);
    chk_eq("R12 reset no result", int'(ok_o) + int'(fail_o) + int'(abort_o), 0);
    chk_eq("R11 reset sent", int'(sent_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    run_reject(2'd1, 0);
    run_reject(2'd3, 4);
    run_vec(VEC[1]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule